// File: doc/BRIEF.md
# Speculative Transaction Tracking Cache

This block is a small direct-mapped data cache that serves one core while it runs code as speculative transactions. Between a begin pulse and an end pulse, loads and stores from the core are served from private line copies. Stores never reach shared memory early. Each line carries a flag for speculative reads and a flag for speculative modification. Each word carries a flag that marks it as written locally. A word-addressed backing array stands in for shared memory.

Other cores publish their committed writes on a snoop port. Every snooped write updates the backing array and refreshes cached words that were not written locally. If the write lands in a line that the running transaction has read, the cache rolls back: it drops every modified line, clears all flags and pulses a restart signal so that the core can replay. On an end pulse the cache requests the right to commit. Once that is granted, it streams every locally written word as address/data beats over a valid/ready channel, marks the final beat, and then pulses commit-done.

Top module: `spec_tx_cache`

## Requirements
- R1: After reset no response, overflow, restart, commit request, packet beat or commit-done is asserted, and backing word at address a holds the value a.
- R2: A load or store that is accepted gives `rspValid` one cycle later. A load returns the current speculative value of the word (the local store data if the word was written in this transaction, otherwise the cached or backing value), and a store echoes its write data.
- R3: Requests are ignored (no response) outside a running transaction, and also in any cycle where `snpValid` is high.
- R4: A load sets its line's read flag unless the word was already stored in this transaction. A snooped write that hits a line with the read flag set causes a violation. Lines that were only written, or that were read only through locally written words, do not.
- R5: A snooped write updates the backing array and the hit word of a cached line, unless that word was written locally, in which case the local value is kept.
- R6: On a violation `restartPulse` is high for exactly one cycle, the transaction ends, lines modified by it are invalidated (later loads see backing values) and all flags are cleared.
- R7: An access whose line slot holds another tag carrying a read or modified flag gives an `overflow` pulse one cycle later instead of a response, and the resident line and its flags are kept.
- R8: After an end pulse `commitReq` stays high until `commitGrant`, and no packet beat appears before the grant.
- R9: After the grant, one beat is sent per locally written word, in ascending slot order (slot = the low index+word address bits, i.e. address modulo lines×words). Each beat carries the full word address and data, and `pktLast` is set on the final beat only. The beat is held stable while `pktReady` is low.
- R10: After the scan finishes, the written data is in the backing array and `commitDone` pulses for one cycle. All flags are cleared, so later snoops to lines read during the transaction cause no violation. A transaction with no stores completes with zero beats.
- R11: A snooped write that hits a read line while waiting for the grant also causes a violation, and `commitReq` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Start a transaction (pulse) |
| txEnd | input | 1 | End the running transaction and ask to commit (pulse) |
| reqValid | input | 1 | Load/store request |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Store data |
| rspValid | output | 1 | Request served, one cycle after acceptance |
| rspData | output | DATA_W | Load data or echoed store data |
| overflow | output | 1 | Access refused because it would evict speculative state |
| snpValid | input | 1 | Committed write from another core |
| snpAddr | input | ADDR_W | Snooped word address |
| snpData | input | DATA_W | Snooped word data |
| restartPulse | output | 1 | Violation detected, transaction rolled back |
| commitReq | output | 1 | Waiting for commit permission |
| commitGrant | input | 1 | Commit permission |
| pktValid | output | 1 | Commit beat valid |
| pktReady | input | 1 | Commit beat accepted |
| pktAddr | output | ADDR_W | Commit beat word address |
| pktData | output | DATA_W | Commit beat data |
| pktLast | output | 1 | Final beat of the commit packet |
| commitDone | output | 1 | Commit packet finished |

## Verification
The bench builds the cache with a 6-bit word address, 16-bit data, 4 lines of 2 words, so the whole 64-word backing array and all 8 commit slots can be swept. With only 8 tags per slot, every address can be loaded through a full begin/commit round. Every slot can be filled by one transaction and streamed under both steady and stalling ready patterns. A final read-back of all 64 words checks every committed and snooped value against the bench's own memory image. With 4 lines, the eviction conflicts that cause overflow and the violations through read or written words can be set up with a handful of addresses.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT,
    ST_SEND
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic access;     // serve the current request
    logic snoop;      // absorb the snooped write
    logic rollback;   // drop speculative state
    logic startSend;  // reset the commit scan cursor
    logic send;       // commit scan running
    logic finish;     // commit scan complete, clear flags
  } dpStrobe_t;

endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txBegin,
  input  logic      txEnd,
  input  logic      reqValid,
  input  logic      snpValid,
  input  logic      commitGrant,
  input  logic      violHit,
  input  logic      sendEnd,
  output dpStrobe_t stb,
  output logic      commitReq,
  output logic      restartPulse,
  output logic      commitDone
);

  txState_e state, stateNext;

  always_comb begin
    stb = '0;
    stb.snoop     = snpValid && (state != ST_SEND);
    stb.access    = reqValid && !snpValid && (state == ST_RUN);
    stb.rollback  = violHit && ((state == ST_RUN) || (state == ST_WAIT));
    stb.startSend = (state == ST_WAIT) && commitGrant && !stb.rollback;
    stb.send      = (state == ST_SEND);
    stb.finish    = stb.send && sendEnd;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (txBegin) stateNext = ST_RUN;
      ST_RUN: begin
        if (stb.rollback)  stateNext = ST_IDLE;
        else if (txEnd)    stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (stb.rollback)       stateNext = ST_IDLE;
        else if (stb.startSend) stateNext = ST_SEND;
      end
      ST_SEND: if (stb.finish) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      restartPulse <= 1'b0;
      commitDone   <= 1'b0;
    end else begin
      state        <= stateNext;
      restartPulse <= stb.rollback;
      commitDone   <= stb.finish;
    end
  end

  assign commitReq = (state == ST_WAIT);

endmodule

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 2,
  parameter int NUM_LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  input  logic              pktReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              overflow,
  output logic              violHit,
  output logic              sendEnd,
  output logic              pktValid,
  output logic [ADDR_W-1:0] pktAddr,
  output logic [DATA_W-1:0] pktData,
  output logic              pktLast
);

  localparam int WORD_W    = $clog2(LINE_WORDS);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int SLOT_W    = IDX_W + WORD_W;
  localparam int TAG_W     = ADDR_W - SLOT_W;
  localparam int SLOTS     = NUM_LINES * LINE_WORDS;
  localparam int MEM_WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [DATA_W-1:0] lineData [NUM_LINES][LINE_WORDS];
  logic [TAG_W-1:0]  lineTag [NUM_LINES];
  logic [NUM_LINES-1:0] lineValid, readF, modF;
  logic [NUM_LINES-1:0][LINE_WORDS-1:0] renF;
  logic [SLOTS-1:0]  renFlat;
  logic [SLOT_W-1:0] cur;

  logic [WORD_W-1:0] reqWord, snpWord, curWord;
  logic [IDX_W-1:0]  reqIdx, snpIdx, curIdx;
  logic [TAG_W-1:0]  reqTag, snpTag;
  logic reqHit, reqConflict, snpHit, slotLive, laterLive, advance;

  assign reqWord = reqAddr[WORD_W-1:0];
  assign reqIdx  = reqAddr[WORD_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign snpWord = snpAddr[WORD_W-1:0];
  assign snpIdx  = snpAddr[WORD_W +: IDX_W];
  assign snpTag  = snpAddr[ADDR_W-1 -: TAG_W];
  assign curWord = cur[WORD_W-1:0];
  assign curIdx  = cur[SLOT_W-1:WORD_W];

  assign reqHit      = lineValid[reqIdx] && (lineTag[reqIdx] == reqTag);
  assign reqConflict = lineValid[reqIdx] && (lineTag[reqIdx] != reqTag)
                       && (readF[reqIdx] || modF[reqIdx]);
  assign snpHit      = lineValid[snpIdx] && (lineTag[snpIdx] == snpTag);
  assign violHit     = snpValid && snpHit && readF[snpIdx];

  // commit scan over every word slot
  assign renFlat  = renF;
  assign slotLive = renFlat[cur];
  assign pktValid = stb.send && slotLive;
  assign pktAddr  = {lineTag[curIdx], cur};
  assign pktData  = lineData[curIdx][curWord];
  assign advance  = stb.send && (!slotLive || pktReady);
  assign sendEnd  = advance && (cur == SLOT_W'(SLOTS - 1));

  always_comb begin
    laterLive = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if ((s > int'(cur)) && renFlat[s]) laterLive = 1'b1;
    end
  end
  assign pktLast = pktValid && !laterLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= DATA_W'(i);
      for (int l = 0; l < NUM_LINES; l++) begin
        lineTag[l] <= '0;
        for (int k = 0; k < LINE_WORDS; k++) lineData[l][k] <= '0;
      end
      lineValid <= '0;
      readF     <= '0;
      modF      <= '0;
      renF      <= '0;
      cur       <= '0;
      rspValid  <= 1'b0;
      rspData   <= '0;
      overflow  <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      overflow <= 1'b0;

      if (stb.access) begin
        if (reqConflict) begin
          overflow <= 1'b1;
        end else begin
          rspValid <= 1'b1;
          if (!reqHit) begin
            lineValid[reqIdx] <= 1'b1;
            lineTag[reqIdx]   <= reqTag;
            for (int k = 0; k < LINE_WORDS; k++)
              lineData[reqIdx][k] <= mem[{reqTag, reqIdx, WORD_W'(k)}];
            readF[reqIdx] <= 1'b0;
            modF[reqIdx]  <= 1'b0;
            renF[reqIdx]  <= '0;
          end
          if (reqWrite) begin
            lineData[reqIdx][reqWord] <= reqWdata;
            modF[reqIdx]              <= 1'b1;
            renF[reqIdx][reqWord]     <= 1'b1;
            rspData                   <= reqWdata;
          end else begin
            rspData <= reqHit ? lineData[reqIdx][reqWord] : mem[reqAddr];
            if (!(reqHit && renF[reqIdx][reqWord])) readF[reqIdx] <= 1'b1;
          end
        end
      end

      if (stb.snoop) begin
        mem[snpAddr] <= snpData;
        if (snpHit && !renF[snpIdx][snpWord]) lineData[snpIdx][snpWord] <= snpData;
      end

      if (stb.startSend) begin
        cur <= '0;
      end else if (advance) begin
        cur <= cur + 1'b1;
        if (slotLive) mem[pktAddr] <= pktData;
      end

      if (stb.rollback) begin
        for (int l = 0; l < NUM_LINES; l++)
          if (modF[l]) lineValid[l] <= 1'b0;
        readF <= '0;
        modF  <= '0;
        renF  <= '0;
      end else if (stb.finish) begin
        readF <= '0;
        modF  <= '0;
        renF  <= '0;
      end
    end
  end

endmodule

// File: rtl/spec_tx_cache.sv
module spec_tx_cache
  import stc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int LINE_WORDS = 2,
  parameter int NUM_LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txEnd,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              overflow,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData,
  output logic              restartPulse,
  output logic              commitReq,
  input  logic              commitGrant,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [ADDR_W-1:0] pktAddr,
  output logic [DATA_W-1:0] pktData,
  output logic              pktLast,
  output logic              commitDone
);

  dpStrobe_t stb;
  logic violHit, sendEnd;

  stc_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd),
    .reqValid(reqValid), .snpValid(snpValid), .commitGrant(commitGrant),
    .violHit(violHit), .sendEnd(sendEnd), .stb(stb),
    .commitReq(commitReq), .restartPulse(restartPulse), .commitDone(commitDone)
  );

  stc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .snpValid(snpValid),
    .snpAddr(snpAddr), .snpData(snpData), .pktReady(pktReady),
    .rspValid(rspValid), .rspData(rspData), .overflow(overflow),
    .violHit(violHit), .sendEnd(sendEnd), .pktValid(pktValid),
    .pktAddr(pktAddr), .pktData(pktData), .pktLast(pktLast)
  );

endmodule

// File: rtl/stc_chk.sv
module stc_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              snpValid,
  input logic              rspValid,
  input logic              overflow,
  input logic              restartPulse,
  input logic              commitReq,
  input logic              commitGrant,
  input logic              commitDone,
  input logic              pktValid,
  input logic              pktReady,
  input logic [ADDR_W-1:0] pktAddr,
  input logic [DATA_W-1:0] pktData,
  input logic              pktLast
);

  // R3
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid) && !$past(snpValid)));

  // R7
  no_overflow_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !rspValid);

  // R6
  restart_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |=> !restartPulse);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitReq && !commitGrant && !snpValid) |=> commitReq);

  // R8
  no_beat_waiting_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |-> !pktValid);

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktAddr) && $stable(pktData)));

  // R9
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktLast |-> pktValid);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitDone |-> (!commitReq && !pktValid && !restartPulse));

endmodule

bind spec_tx_cache stc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .snpValid(snpValid),
  .rspValid(rspValid), .overflow(overflow), .restartPulse(restartPulse),
  .commitReq(commitReq), .commitGrant(commitGrant), .commitDone(commitDone),
  .pktValid(pktValid), .pktReady(pktReady), .pktAddr(pktAddr),
  .pktData(pktData), .pktLast(pktLast)
);

// File: tb/spec_tx_cache_tb_top.sv
`timescale 1ns/1ps
module spec_tx_cache_tb_top;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int LINE_WORDS = 2;
  localparam int NUM_LINES = 4;
  localparam int SLOTS = LINE_WORDS * NUM_LINES;
  localparam int MEMW = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txBegin = 0, txEnd = 0, reqValid = 0, reqWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic rspValid, overflow, restartPulse, commitReq, pktValid, pktLast, commitDone;
  logic [DATA_W-1:0] rspData, pktData;
  logic [ADDR_W-1:0] pktAddr;
  logic snpValid = 0, commitGrant = 0, pktReady = 0;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic [DATA_W-1:0] snpData = '0;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 0;

  logic [DATA_W-1:0] model [MEMW];
  logic [DATA_W-1:0] wrData [MEMW];
  bit written [MEMW];

  always #2.5 clk = ~clk;

  spec_tx_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)) dut_i (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txEnd(txEnd),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .overflow(overflow),
    .snpValid(snpValid), .snpAddr(snpAddr), .snpData(snpData),
    .restartPulse(restartPulse), .commitReq(commitReq), .commitGrant(commitGrant),
    .pktValid(pktValid), .pktReady(pktReady), .pktAddr(pktAddr), .pktData(pktData),
    .pktLast(pktLast), .commitDone(commitDone)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int a, input int d,
                        output bit v, output logic [DATA_W-1:0] rd, output bit ovf);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(a); reqWdata = DATA_W'(d);
    @(negedge clk);
    v = rspValid; rd = rspData; ovf = overflow;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic load(input int a, input logic [DATA_W-1:0] exp, input string rq);
    bit v, o; logic [DATA_W-1:0] rd;
    access(1'b0, a, 0, v, rd, o);
    check(v && !o, rq, "load accepted", int'(v), 1);
    check(rd == exp, rq, "load data", int'(rd), int'(exp));
  endtask

  task automatic store(input int a, input int d, input string rq);
    bit v, o; logic [DATA_W-1:0] rd;
    access(1'b1, a, d, v, rd, o);
    check(v && !o && rd == DATA_W'(d), rq, "store echo", int'(rd), d);
    if (v) begin written[a] = 1'b1; wrData[a] = DATA_W'(d); end
  endtask

  task automatic beginTx();
    for (int i = 0; i < MEMW; i++) written[i] = 1'b0;
    txBegin = 1'b1;
    @(negedge clk);
    txBegin = 1'b0;
  endtask

  task automatic snoop(input int a, input int d, output bit rs);
    snpValid = 1'b1; snpAddr = ADDR_W'(a); snpData = DATA_W'(d);
    @(negedge clk);
    rs = restartPulse;
    snpValid = 1'b0;
    model[a] = DATA_W'(d);
  endtask

  task automatic commitTx(input int readyMode, input string rq);
    int expAddr [SLOTS];
    int n = 0;
    int beats = 0;
    int cyc = 0;
    bit seenDone = 0;
    for (int s = 0; s < SLOTS; s++)
      for (int a = 0; a < MEMW; a++)
        if (written[a] && (a % SLOTS) == s) begin expAddr[n] = a; n++; end
    txEnd = 1'b1;
    @(negedge clk);
    txEnd = 1'b0;
    check(commitReq == 1'b1, "R8", "commit request after end", int'(commitReq), 1);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      check(commitReq && !pktValid, "R8", "held without grant", int'(pktValid), 0);
    end
    commitGrant = 1'b1;
    @(negedge clk);
    commitGrant = 1'b0;
    while (cyc < 200) begin
      if (commitDone) begin seenDone = 1; break; end
      pktReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 2);
      if (pktValid && pktReady) begin
        if (beats < n) begin
          check(int'(pktAddr) == expAddr[beats], rq, "beat address",
                int'(pktAddr), expAddr[beats]);
          check(pktData == wrData[expAddr[beats]], rq, "beat data",
                int'(pktData), int'(wrData[expAddr[beats]]));
          check(pktLast == (beats == n - 1), rq, "beat last flag",
                int'(pktLast), int'(beats == n - 1));
        end
        beats++;
      end
      @(negedge clk);
      cyc++;
    end
    pktReady = 1'b0;
    check(beats == n, "R9", "beat count", beats, n);
    check(seenDone, "R10", "commit done pulse", int'(seenDone), 1);
    for (int a = 0; a < MEMW; a++) if (written[a]) model[a] = wrData[a];
    for (int i = 0; i < MEMW; i++) written[i] = 1'b0;
  endtask

  task automatic sweepLoads(input string rq);
    for (int a = 0; a < MEMW; a++) begin
      beginTx();
      load(a, model[a], rq);
      commitTx(0, "R10");
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      chkCnt++;
      errCnt++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    bit v, o, rs;
    logic [DATA_W-1:0] rd;
    for (int a = 0; a < MEMW; a++) begin model[a] = DATA_W'(a); written[a] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(!rspValid && !overflow && !restartPulse && !commitReq && !pktValid && !commitDone,
          "R1", "outputs idle after reset", 1, 0);

    // R3 request outside a transaction
    access(1'b0, 5, 0, v, rd, o);
    check(!v && !o, "R3", "no response while idle", int'(v), 0);

    // R1 R2 initial memory through every address, empty commits (R10)
    sweepLoads("R1");

    // R2 R9 store sweep over every slot for every tag
    for (int t = 0; t < MEMW / SLOTS; t++) begin
      beginTx();
      for (int s = 0; s < SLOTS; s++) store(t * SLOTS + s, 'h5000 + t * 32 + s * 3, "R2");
      for (int s = SLOTS - 1; s >= 0; s--)
        load(t * SLOTS + s, DATA_W'('h5000 + t * 32 + s * 3), "R2");
      commitTx(t % 2, "R9");
    end

    // R4 R6 violation through a read line
    beginTx();
    store(8, 'hBEEF, "R6");
    load(4, model[4], "R2");
    snoop(5, 'h1234, rs);
    check(rs, "R4", "violation on read line", int'(rs), 1);
    for (int i = 0; i < MEMW; i++) written[i] = 0;
    @(negedge clk);
    check(!restartPulse && !commitReq, "R6", "single restart, back to idle",
          int'(restartPulse), 0);
    access(1'b0, 8, 0, v, rd, o);
    check(!v, "R6", "transaction ended", int'(v), 0);
    beginTx();
    load(8, model[8], "R6");
    load(5, 16'h1234, "R5");
    commitTx(0, "R10");

    // R4 R5 renamed words
    beginTx();
    store(20, 'h7777, "R4");
    load(20, 16'h7777, "R2");
    snoop(20, 'h0BAD, rs);
    check(!rs, "R4", "no violation via written word", int'(rs), 0);
    load(20, 16'h7777, "R5");
    snoop(21, 'h4242, rs);
    check(!rs, "R4", "no violation via written-only line", int'(rs), 0);
    load(21, 16'h4242, "R5");
    commitTx(1, "R9");

    // R5 snoops on lines not read
    beginTx();
    load(4, model[4], "R2");
    snoop(12, 'h0C12, rs);
    check(!rs, "R5", "no violation for other tag", int'(rs), 0);
    snoop(0, 'h0C0C, rs);
    check(!rs, "R5", "no violation unread line", int'(rs), 0);
    load(0, 16'h0C0C, "R5");
    commitTx(0, "R10");

    // R7 overflow on a read line
    beginTx();
    load(1, model[1], "R2");
    access(1'b0, 9, 0, v, rd, o);
    check(o && !v, "R7", "load overflow", int'(o), 1);
    snoop(1, 'h3131, rs);
    check(rs, "R7", "resident read line kept", int'(rs), 1);
    for (int i = 0; i < MEMW; i++) written[i] = 0;
    @(negedge clk);

    // R7 overflow on a modified line
    beginTx();
    store(3, 'hAAAA, "R2");
    access(1'b1, 11, 'h1111, v, rd, o);
    check(o && !v, "R7", "store overflow", int'(o), 1);
    commitTx(1, "R7");

    // R11 violation while waiting for grant
    beginTx();
    load(2, model[2], "R2");
    txEnd = 1'b1;
    @(negedge clk);
    txEnd = 1'b0;
    check(commitReq, "R8", "request raised", int'(commitReq), 1);
    snoop(2, 'h2222, rs);
    check(rs && !commitReq, "R11", "violation while waiting", int'(rs), 1);
    @(negedge clk);

    // R3 request blocked by a concurrent snoop
    beginTx();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 6'd6;
    snpValid = 1'b1; snpAddr = 6'd40; snpData = 16'h4040;
    @(negedge clk);
    check(!rspValid, "R3", "no response beside snoop", int'(rspValid), 0);
    reqValid = 1'b0; snpValid = 1'b0;
    model[40] = 16'h4040;
    load(6, model[6], "R2");
    commitTx(0, "R10");

    // R10 flags cleared after commit
    snoop(6, 'h0606, rs);
    check(!rs, "R10", "no violation after commit", int'(rs), 0);

    // R10 full read-back of the memory image
    sweepLoads("R10");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule